// File: doc/BRIEF.md
# Modem Command Responder with Sticky Event Line

This block is the slave-side command and status logic of a low-power radio modem. A host exchanges bytes with it through an SPI byte layer: each frame (chip select active) starts with an opcode byte, and on every byte position the block returns one response byte that was registered one exchange earlier. The block stores a transmit payload, a receive buffer and identity bytes, mirrors a small general-purpose port, and keeps a packed device status byte. An active-low event line tells the host that something has finished.

Radio, non-volatile memory and measurement hardware are not present. A single stub timer stands in for them. A start opcode loads the timer with a per-operation cycle count, and the timer's completion pulse drives the event line and the status flags. A send-and-receive completion also fills the receive buffer with the payload XOR a fixed mask. The host reads the status with a dedicated opcode, and that read also clears it.

Top module: `mdm_event_resp`

## Requirements
- R1: After reset `event_n` stays high while the power-up timer runs (PWRUP_CYC cycles). It then goes low, and the device status byte shows ready (bit 6). `event_n` only falls in the cycle after a timer completion.
- R2: In every frame, response positions 0 and 1 are 0x00. Opcode 0x0A returns a busy byte (bit 0 = timer running) at position 2, the device status byte at position 3 and 0x00 at position 4. It releases `event_n` high in the cycle after the opcode byte and clears ready, frame-sent and the error code, so a second read returns 0x00 at position 3.
- R3: The device status byte is {0, ready, frame sent, error[3:0], PA on}. PA on (bit 0) is 1 while a transmit or send-and-receive operation is running. The error code is 0000 none, 0001 unsupported, 0010 generic, 0011 frequency, 0100 usage, 0101 opening, 0110 closing, 0111 send.
- R4: Opcode 0x0D runs for TX_CYC cycles. On completion it sets frame sent and pulls `event_n` low.
- R5: Opcode 0x0E runs for TXRX_CYC cycles. On completion it sets frame sent, pulls `event_n` low and loads receive byte i with payload byte i XOR 0x5A (payload bytes past the stored length are 0).
- R6: Opcode 0x14 (measurement) and opcode 0x11 (configuration write) each pull `event_n` low on completion and set no status flag.
- R7: Opcodes 0x00, 0x08, 0x0C, 0x18, 0x19, 0x1A and anything above 0x1C record error code 0001 and leave `event_n` unchanged.
- R8: Opcode 0x07 takes a length byte at position 1 and payload bytes from position 2. A length of 0 to 12 replaces the whole payload; bytes past the length are dropped, and old bytes past the new length read as 0. A length above 12 records error code 0100 and keeps the previous payload.
- R9: Opcode 0x10 returns the 8 receive bytes at positions 2 to 9, and 0x00 after them.
- R10: Opcode 0x0F returns 16 identity bytes at positions 2 to 17. Byte i is ID_BASE+i for i below 8, and the upper 8 are 0x00.
- R11: Opcode 0x02 writes `port_dir` from position 1 with bit 0 forced to 0. Opcode 0x03 writes `port_out` with bit 0 forced to 1. Opcode 0x04 returns {2'b00, pin_in[5:1], 1} at position 2.
- R12: A start opcode (0x0D, 0x0E, 0x11, 0x14) that arrives while the timer runs records error code 0100 and is ignored.
- R13: Opcode 0x01 restarts the power-up timer at any time and clears ready. Ready and a low `event_n` return after PWRUP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_act | input | 1 | High for the duration of a host frame |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` is exchanged at this position |
| byte_in | input | 8 | Byte from the host |
| pin_in | input | PORT_W | Levels on the general-purpose port pins |
| byte_out | output | 8 | Response byte for the next exchanged position |
| event_n | output | 1 | Active-low sticky event line |
| port_dir | output | PORT_W | Port direction register (1 = output) |
| port_out | output | PORT_W | Port output / pull-up register |

## Verification
Read-only opcodes are driven from a table of (opcode, position, expected byte) entries. These show that each opcode has its own byte layout, including the dummy positions, the zeroed identity tail and the forced port bit. Send-and-receive is run with a short payload, a full 12-byte payload, an over-long length and a length followed by surplus bytes. The resulting receive bytes tell whether the payload was stored, kept or cleared. Status reads taken during an operation, after a rejected start, after reserved opcodes and after each completion show the packed error field, the PA bit and clear-on-read apart from one another, and show the event line falling only when a timer completes.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [2:0] {
    OPK_NONE, OPK_PWRUP, OPK_TX, OPK_TXRX, OPK_MEAS, OPK_CFG
  } opk_e;

  localparam logic [7:0] OP_SYSRST  = 8'h01;
  localparam logic [7:0] OP_DIR     = 8'h02;
  localparam logic [7:0] OP_OUT     = 8'h03;
  localparam logic [7:0] OP_PIN     = 8'h04;
  localparam logic [7:0] OP_PAYLOAD = 8'h07;
  localparam logic [7:0] OP_STATUS  = 8'h0A;
  localparam logic [7:0] OP_SEND    = 8'h0D;
  localparam logic [7:0] OP_SENDRX  = 8'h0E;
  localparam logic [7:0] OP_IDENT   = 8'h0F;
  localparam logic [7:0] OP_RXBUF   = 8'h10;
  localparam logic [7:0] OP_CONF    = 8'h11;
  localparam logic [7:0] OP_MEAS    = 8'h14;
  localparam logic [7:0] OP_LAST    = 8'h1C;

  localparam logic [3:0] ERR_CMD    = 4'h1;
  localparam logic [3:0] ERR_USAGE  = 4'h4;
endpackage

// File: rtl/mdm_opdec.sv
module mdm_opdec
  import mdm_pkg::*;
(
  input  logic [7:0] op,
  output logic       unsupported,
  output logic       starts,
  output opk_e       kind
);
  always_comb begin
    unsupported = (op == 8'h00) || (op == 8'h08) || (op == 8'h0C) ||
                  ((op >= 8'h18) && (op <= 8'h1A)) || (op > OP_LAST);
    case (op)
      OP_SYSRST: kind = OPK_PWRUP;
      OP_SEND:   kind = OPK_TX;
      OP_SENDRX: kind = OPK_TXRX;
      OP_MEAS:   kind = OPK_MEAS;
      OP_CONF:   kind = OPK_CFG;
      default:   kind = OPK_NONE;
    endcase
    starts = (kind != OPK_NONE);
  end
endmodule

// File: rtl/mdm_op_timer.sv
module mdm_op_timer
  import mdm_pkg::*;
#(
  parameter int PWRUP_CYC = 40,
  parameter int TX_CYC    = 100,
  parameter int TXRX_CYC  = 160,
  parameter int MEAS_CYC  = 30,
  parameter int CFG_CYC   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  opk_e load_kind,
  output logic busy,
  output opk_e kind,
  output logic done
);
  localparam int M1   = (PWRUP_CYC > TX_CYC) ? PWRUP_CYC : TX_CYC;
  localparam int M2   = (TXRX_CYC > MEAS_CYC) ? TXRX_CYC : MEAS_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > CFG_CYC) ? M3 : CFG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] len_of(opk_e k);
    case (k)
      OPK_PWRUP: len_of = CW'(PWRUP_CYC);
      OPK_TX:    len_of = CW'(TX_CYC);
      OPK_TXRX:  len_of = CW'(TXRX_CYC);
      OPK_MEAS:  len_of = CW'(MEAS_CYC);
      OPK_CFG:   len_of = CW'(CFG_CYC);
      default:   len_of = CW'(2);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(PWRUP_CYC);
      kind <= OPK_PWRUP;
      busy <= 1'b1;
    end else if (load) begin
      cnt  <= len_of(load_kind);
      kind <= load_kind;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign done = busy && (cnt == CW'(1)) && !load;

  // R4: a running count steps down by one each cycle
  p_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && cnt != CW'(1)) |=> (busy && cnt == $past(cnt) - CW'(1)));
  // R4: completion ends the busy phase
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/mdm_status.sv
module mdm_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       evt_set,
  input  logic       set_ready,
  input  logic       clr_ready,
  input  logic       set_sent,
  input  logic       err_we,
  input  logic [3:0] err_code,
  input  logic       pa_on,
  output logic [7:0] dev_byte,
  output logic       event_n
);
  logic       ready_q, sent_q;
  logic [3:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      sent_q  <= 1'b0;
      err_q   <= 4'h0;
      event_n <= 1'b1;
    end else begin
      if (clr) begin
        ready_q <= 1'b0;
        sent_q  <= 1'b0;
        err_q   <= 4'h0;
        event_n <= 1'b1;
      end
      if (clr_ready) ready_q <= 1'b0;
      if (set_ready) ready_q <= 1'b1;
      if (set_sent)  sent_q  <= 1'b1;
      if (err_we)    err_q   <= err_code;
      if (evt_set)   event_n <= 1'b0;
    end
  end

  assign dev_byte = {1'b0, ready_q, sent_q, err_q, pa_on};

  // R1: the event line only falls after a completion pulse
  p_event_src_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(event_n) |-> $past(evt_set));
  // R2: a status read without a simultaneous completion releases the line
  p_event_release_r2: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt_set) |=> event_n);
endmodule

// File: rtl/mdm_event_resp.sv
module mdm_event_resp
  import mdm_pkg::*;
#(
  parameter int         PAY_MAX   = 12,
  parameter int         RX_LEN    = 8,
  parameter int         ID_USED   = 8,
  parameter logic [7:0] ID_BASE   = 8'hB0,
  parameter logic [7:0] RX_MASK   = 8'h5A,
  parameter int         PORT_W    = 6,
  parameter int         IDX_W     = 6,
  parameter int         PWRUP_CYC = 40,
  parameter int         TX_CYC    = 100,
  parameter int         TXRX_CYC  = 160,
  parameter int         MEAS_CYC  = 30,
  parameter int         CFG_CYC   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_act,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic [PORT_W-1:0] pin_in,
  output logic [7:0]        byte_out,
  output logic              event_n,
  output logic [PORT_W-1:0] port_dir,
  output logic [PORT_W-1:0] port_out
);
  localparam int LEN_W = $clog2(PAY_MAX + 1);
  localparam int PI_W  = $clog2(PAY_MAX);
  localparam int RI_W  = $clog2(RX_LEN);

  logic [IDX_W-1:0] idx, dpos, pidx;
  logic [7:0]       op_q, snap_hw, snap_dev, dev_byte, resp_nxt;
  logic [7:0]       pay [PAY_MAX];
  logic [7:0]       rx  [RX_LEN];
  logic [LEN_W-1:0] pay_len;
  logic             pay_ok, first, step;
  logic             dec_bad, dec_start;
  opk_e             dec_kind, tkind;
  logic             busy, done, tmr_load, clr_ready;
  logic             err_we;
  logic [3:0]       err_code;
  logic             len_bad;

  assign step  = frame_act && byte_vld;
  assign first = step && (idx == '0);
  assign dpos  = idx - IDX_W'(1);
  assign pidx  = idx - IDX_W'(2);

  mdm_opdec u_dec (
    .op(byte_in), .unsupported(dec_bad), .starts(dec_start), .kind(dec_kind)
  );

  mdm_op_timer #(
    .PWRUP_CYC(PWRUP_CYC), .TX_CYC(TX_CYC), .TXRX_CYC(TXRX_CYC),
    .MEAS_CYC(MEAS_CYC), .CFG_CYC(CFG_CYC)
  ) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_kind(dec_kind),
    .busy(busy), .kind(tkind), .done(done)
  );

  // command side effects decided on the opcode and length bytes
  always_comb begin
    tmr_load  = first && dec_start && ((dec_kind == OPK_PWRUP) || !busy);
    clr_ready = tmr_load && (dec_kind == OPK_PWRUP);
    len_bad   = step && (idx == IDX_W'(1)) && (op_q == OP_PAYLOAD) &&
                (byte_in > 8'(PAY_MAX));
    err_we    = 1'b0;
    err_code  = 4'h0;
    if (first && dec_bad) begin
      err_we   = 1'b1;
      err_code = ERR_CMD;
    end else if ((first && dec_start && dec_kind != OPK_PWRUP && busy) || len_bad) begin
      err_we   = 1'b1;
      err_code = ERR_USAGE;
    end
  end

  mdm_status u_st (
    .clk(clk), .rst(rst),
    .clr(first && byte_in == OP_STATUS),
    .evt_set(done),
    .set_ready(done && tkind == OPK_PWRUP),
    .clr_ready(clr_ready),
    .set_sent(done && (tkind == OPK_TX || tkind == OPK_TXRX)),
    .err_we(err_we), .err_code(err_code),
    .pa_on(busy && (tkind == OPK_TX || tkind == OPK_TXRX)),
    .dev_byte(dev_byte), .event_n(event_n)
  );

  // response for the position following the one now exchanged
  always_comb begin
    resp_nxt = 8'h00;
    if (idx != '0) begin
      case (op_q)
        OP_STATUS: begin
          if (dpos == IDX_W'(0)) resp_nxt = snap_hw;
          else if (dpos == IDX_W'(1)) resp_nxt = snap_dev;
        end
        OP_RXBUF: if (int'(dpos) < RX_LEN) resp_nxt = rx[dpos[RI_W-1:0]];
        OP_IDENT: if (int'(dpos) < ID_USED) resp_nxt = ID_BASE + 8'(dpos);
        OP_PIN:   if (dpos == IDX_W'(0)) resp_nxt = 8'({pin_in[PORT_W-1:1], 1'b1});
        default:  resp_nxt = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !frame_act) begin
      idx      <= '0;
      byte_out <= 8'h00;
    end else if (byte_vld) begin
      byte_out <= resp_nxt;
      if (idx != '1) idx <= idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= 8'h00;
      snap_hw  <= 8'h00;
      snap_dev <= 8'h00;
      port_dir <= '0;
      port_out <= PORT_W'(1);
      pay_len  <= '0;
      pay_ok   <= 1'b0;
      for (int i = 0; i < PAY_MAX; i++) pay[i] <= 8'h00;
      for (int i = 0; i < RX_LEN; i++)  rx[i]  <= 8'h00;
    end else begin
      if (step) begin
        if (idx == '0) begin
          op_q <= byte_in;
          if (byte_in == OP_STATUS) begin
            snap_hw  <= {7'b0, busy};
            snap_dev <= dev_byte;
          end
        end else if (idx == IDX_W'(1)) begin
          case (op_q)
            OP_DIR: port_dir <= {byte_in[PORT_W-1:1], 1'b0};
            OP_OUT: port_out <= {byte_in[PORT_W-1:1], 1'b1};
            OP_PAYLOAD: begin
              if (!len_bad) begin
                pay_len <= LEN_W'(byte_in);
                pay_ok  <= 1'b1;
                for (int i = 0; i < PAY_MAX; i++) pay[i] <= 8'h00;
              end else begin
                pay_ok <= 1'b0;
              end
            end
            default: ;
          endcase
        end else if (op_q == OP_PAYLOAD && pay_ok && int'(pidx) < int'(pay_len)) begin
          pay[pidx[PI_W-1:0]] <= byte_in;
        end
      end
      if (done && tkind == OPK_TXRX) begin
        for (int i = 0; i < RX_LEN; i++)
          rx[i] <= ((i < PAY_MAX) ? pay[i] : 8'h00) ^ RX_MASK;
      end
    end
  end

  // R8: the stored length never exceeds the payload capacity
  p_len_bound_r8: assert property (@(posedge clk) disable iff (rst)
    int'(pay_len) <= PAY_MAX);
  // R2: the response to position 1 is always a zero dummy
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (first) |=> (byte_out == 8'h00));
  // R13: a restart clears the ready flag on the next cycle
  p_restart_r13: assert property (@(posedge clk) disable iff (rst)
    clr_ready |=> !dev_byte[6]);
endmodule

// File: tb/sim_mdm_event_resp.sv
module sim_mdm_event_resp;
  localparam int PWRUP = 40, TXC = 100, TXRXC = 160, MEASC = 30, CFGC = 24;

  logic       clk = 0, rst = 1, frame_act = 0, byte_vld = 0;
  logic [7:0] byte_in = 0;
  logic [5:0] pin_in = 6'b101010;
  logic [7:0] byte_out;
  logic       event_n;
  logic [5:0] port_dir, port_out;

  int total = 0, bad = 0;
  logic [7:0] mosi [20];
  logic [7:0] miso [20];

  always #4 clk = ~clk;

  mdm_event_resp u0 (
    .clk(clk), .rst(rst), .frame_act(frame_act), .byte_vld(byte_vld),
    .byte_in(byte_in), .pin_in(pin_in), .byte_out(byte_out),
    .event_n(event_n), .port_dir(port_dir), .port_out(port_out)
  );

  // {opcode, position, expected}
  localparam logic [23:0] VEC [11] = '{
    {8'h0F, 8'd0,  8'h00}, {8'h0F, 8'd1,  8'h00}, {8'h0F, 8'd2,  8'hB0},
    {8'h0F, 8'd5,  8'hB3}, {8'h0F, 8'd9,  8'hB7}, {8'h0F, 8'd10, 8'h00},
    {8'h0F, 8'd17, 8'h00}, {8'h10, 8'd2,  8'h00}, {8'h10, 8'd9,  8'h00},
    {8'h04, 8'd2,  8'h2B}, {8'h04, 8'd3,  8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mosi(input logic [7:0] op);
    for (int i = 0; i < 20; i++) mosi[i] = 8'h00;
    mosi[0] = op;
  endtask

  task automatic run_frame(input int n);
    @(negedge clk) frame_act = 1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      miso[k]  = byte_out;
      byte_in  = mosi[k];
      byte_vld = 1;
      @(negedge clk);
    end
    byte_vld  = 0;
    frame_act = 0;
    wait_cyc(2);
  endtask

  task automatic cmd1(input logic [7:0] op);
    clear_mosi(op);
    run_frame(1);
  endtask

  task automatic get_status(input string tag, input logic [7:0] hw, input logic [7:0] dev);
    clear_mosi(8'h0A);
    run_frame(5);
    chk({tag, " R2 dummy0"}, miso[0], 8'h00);
    chk({tag, " R2 dummy1"}, miso[1], 8'h00);
    chk({tag, " R2 busy byte"}, miso[2], hw);
    chk({tag, " R3 device byte"}, miso[3], dev);
    chk({tag, " R2 lib byte"}, miso[4], 8'h00);
    chk({tag, " R2 event released"}, {7'b0, event_n}, 8'h01);
  endtask

  task automatic read_rx(input int pos, input logic [7:0] exp, input string tag);
    clear_mosi(8'h10);
    run_frame(pos + 1);
    chk(tag, miso[pos], exp);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    chk("R1 event high in reset", {7'b0, event_n}, 8'h01);
    rst = 0;
    wait_cyc(PWRUP - 5);
    chk("R1 event high during power-up", {7'b0, event_n}, 8'h01);
    wait_cyc(10);
    chk("R1 event low after power-up", {7'b0, event_n}, 8'h00);

    get_status("first read", 8'h00, 8'h40);
    get_status("second read R2", 8'h00, 8'h00);

    // table walk: read-only layouts (R9, R10, R11)
    for (int v = 0; v < 11; v++) begin
      clear_mosi(VEC[v][23:16]);
      run_frame(int'(VEC[v][15:8]) + 1);
      chk($sformatf("R9 R10 R11 table row %0d", v), miso[VEC[v][15:8]], VEC[v][7:0]);
    end

    // port writes R11
    clear_mosi(8'h02); mosi[1] = 8'hFF; run_frame(2);
    chk("R11 dir bit0", {2'b0, port_dir}, 8'h3E);
    clear_mosi(8'h03); mosi[1] = 8'h00; run_frame(2);
    chk("R11 out bit0", {2'b0, port_out}, 8'h01);

    // reserved opcodes R7
    begin
      logic [7:0] rsv [7] = '{8'h08, 8'h0C, 8'h18, 8'h19, 8'h1A, 8'h00, 8'h1D};
      for (int r = 0; r < 7; r++) begin
        cmd1(rsv[r]);
        chk($sformatf("R7 no event op %02h", rsv[r]), {7'b0, event_n}, 8'h01);
        get_status("R7 reserved", 8'h00, 8'h02);
      end
    end

    // payload + send/receive, busy rejection R5 R12 R3
    clear_mosi(8'h07); mosi[1] = 8'd3; mosi[2] = 8'h11; mosi[3] = 8'h22; mosi[4] = 8'h33;
    run_frame(5);
    cmd1(8'h0E);
    wait_cyc(10);
    get_status("R3 pa during txrx", 8'h01, 8'h01);
    cmd1(8'h0D);
    get_status("R12 busy start", 8'h01, 8'h09);
    wait_cyc(TXRXC);
    chk("R5 event after txrx", {7'b0, event_n}, 8'h00);
    get_status("R5 sent", 8'h00, 8'h20);
    read_rx(2, 8'h4B, "R5 rx0");
    read_rx(3, 8'h78, "R5 rx1");
    read_rx(4, 8'h69, "R5 rx2");
    read_rx(9, 8'h5A, "R9 rx7 past length");
    read_rx(10, 8'h00, "R9 after rx bytes");

    // full-length payload R8
    clear_mosi(8'h07); mosi[1] = 8'd12;
    for (int i = 0; i < 12; i++) mosi[2 + i] = 8'h10 + 8'(i);
    run_frame(14);
    get_status("R8 len 12 accepted", 8'h00, 8'h00);
    // over-long length keeps old payload
    clear_mosi(8'h07); mosi[1] = 8'd13; mosi[2] = 8'hEE;
    run_frame(3);
    get_status("R8 len 13 rejected", 8'h00, 8'h08);
    cmd1(8'h0E);
    wait_cyc(TXRXC + 5);
    get_status("R5 second txrx", 8'h00, 8'h20);
    read_rx(2, 8'h4A, "R8 payload kept rx0");
    read_rx(9, 8'h4D, "R8 payload full rx7");
    // surplus bytes ignored, stale tail cleared
    clear_mosi(8'h07); mosi[1] = 8'd2; mosi[2] = 8'hAA; mosi[3] = 8'hBB; mosi[4] = 8'hCC;
    run_frame(5);
    cmd1(8'h0E);
    wait_cyc(TXRXC + 5);
    get_status("R5 third txrx", 8'h00, 8'h20);
    read_rx(2, 8'hF0, "R8 short rx0");
    read_rx(3, 8'hE1, "R8 short rx1");
    read_rx(4, 8'h5A, "R8 surplus dropped rx2");

    // plain send R4
    cmd1(8'h0D);
    wait_cyc(TXC - 10);
    chk("R4 event high while sending", {7'b0, event_n}, 8'h01);
    wait_cyc(15);
    chk("R4 event low after send", {7'b0, event_n}, 8'h00);
    get_status("R4 sent", 8'h00, 8'h20);

    // measurement and configuration R6
    cmd1(8'h14);
    wait_cyc(MEASC + 5);
    chk("R6 measure event", {7'b0, event_n}, 8'h00);
    get_status("R6 measure", 8'h00, 8'h00);
    clear_mosi(8'h11); mosi[1] = 8'h3E; mosi[2] = 8'h01; mosi[3] = 8'h02; mosi[4] = 8'h0F;
    run_frame(5);
    wait_cyc(CFGC + 5);
    chk("R6 config event", {7'b0, event_n}, 8'h00);
    get_status("R6 config", 8'h00, 8'h00);

    // restart R13
    cmd1(8'h01);
    chk("R13 event high after restart", {7'b0, event_n}, 8'h01);
    get_status("R13 during restart", 8'h01, 8'h00);
    wait_cyc(PWRUP + 5);
    chk("R13 event low after restart", {7'b0, event_n}, 8'h00);
    get_status("R13 ready again", 8'h00, 8'h40);

    finish_run();
  end
endmodule